// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside a shared-memory interconnect and lets several processors build atomic read-modify-write sequences from a load-linked (LL) followed by a store-conditional (SC). Each processor port owns one reservation slot. A slot holds a cache-line index and a valid flag. An LL arms the slot with the line it loaded. The loaded value comes from the memory system, which lies outside this block.

The monitor watches two sources of writes. The first is the line-granular write/invalidate observation port from the coherent bus. The second is the stores that it releases itself. When a processor presents an SC, the monitor checks whether that processor still holds an intact reservation on the addressed line. If it does, the monitor emits exactly one store toward memory and reports success. If it does not, it reports failure and emits nothing, so a failed SC causes no write and no invalidation traffic.

Only one SC store leaves the block per cycle. Competing eligible SCs in the same cycle are ordered by a fixed-priority pick whose direction is a parameter. A successful SC removes every reservation on its line, so every later SC to that line from any other holder fails.

Top module: `llsc_monitor`

## Requirements
- R1: After reset every reservation slot is empty, and `sc_done`, `sc_pass` and `st_valid` are all 0.
- R2: An LL on port p arms p's slot with the given line. A following SC from p to that line passes, and it drives `st_valid`=1 with `st_addr`, `st_data` equal to the SC address and data and `st_src`=p.
- R3: An SC that fails reports `sc_done`=1 and `sc_pass`=0 for its port, and no store is released for it. When no SC passes in a cycle, `st_valid` is 0.
- R4: An observed write on the snoop port from a source other than p, to the line reserved by p, empties p's slot. An observed write whose source is p itself leaves p's slot unchanged.
- R5: Reservations are kept per line, where the line is the address bits from bit LINE_OFF upward. An SC to any word of the reserved line can pass. An SC to a different line fails.
- R6: A passing SC empties every slot that holds its line, so later SCs to that line from other holders fail. In a spin-lock acquire, at most one SC passes per release.
- R7: An SC from a port whose slot is empty fails.
- R8: When several SCs are eligible in the same cycle, only one passes. With the default order this is the lowest port index, and at most one store is released per cycle.
- R9: Any SC empties the issuing port's own slot, whether it passes or fails. A new LL replaces the slot's previous line.
- R10: An observed write from another source that hits the SC's line in the same cycle as the SC makes that SC fail.
- R11: `sc_done`, `sc_pass` and the store outputs appear exactly one clock after the SC request is sampled. An LL sampled in the same cycle as a competing winner still arms its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_valid | input | N_PORTS | LL request, one bit per port |
| ll_line | input | N_PORTS*LW | Line index of each port's LL, port i at bits [i*LW +: LW] |
| sc_valid | input | N_PORTS | SC request, one bit per port |
| sc_addr | input | N_PORTS*ADDR_W | Byte address of each port's SC |
| sc_data | input | N_PORTS*DATA_W | Store data of each port's SC |
| snoop_valid | input | 1 | An observed write or invalidation on the bus |
| snoop_line | input | LW | Line index of the observed write |
| snoop_src | input | PW | Port index that caused the observed write |
| sc_done | output | N_PORTS | SC outcome is valid for this port |
| sc_pass | output | N_PORTS | SC succeeded (1) or failed (0) |
| st_valid | output | 1 | A store released by a passing SC |
| st_addr | output | ADDR_W | Address of the released store |
| st_data | output | DATA_W | Data of the released store |
| st_src | output | PW | Port that owns the released store |

## Verification
The assertions watch every cycle for the following:
- at most one passing SC;
- no store released in a cycle where every SC failed;
- no pass from an empty slot;
- no pass when a same-cycle foreign snoop hits the line;
- correct arming and clearing of each slot.

Only the bench's scenarios can show the rest. These are that exactly the right port wins among competitors, that line granularity holds across different word offsets, and that a spin-lock acquire yields one owner per release. A reference model runs alongside constrained-random traffic over a few hot lines to cover the interleavings.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

   // Direction of the fixed-priority pick among simultaneous eligible SCs.
   typedef enum logic {
      PRIO_LOW_FIRST  = 1'b0,
      PRIO_HIGH_FIRST = 1'b1
   } prio_e;

endpackage

// File: rtl/llsc_resv_slot.sv
// One reservation register: line index plus valid flag.
module llsc_resv_slot #(
   parameter int LW  = 26,
   parameter int PW  = 2,
   parameter int IDX = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ll_set,
   input  logic [LW-1:0] ll_line,
   input  logic          own_sc,
   input  logic          win_v,
   input  logic [LW-1:0] win_line,
   input  logic          snp_v,
   input  logic [LW-1:0] snp_line,
   input  logic [PW-1:0] snp_src,
   output logic          res_v,
   output logic [LW-1:0] res_line
);

   logic hit_win;
   logic hit_snp;

   assign hit_win = win_v && (win_line == res_line);
   assign hit_snp = snp_v && (snp_src != PW'(IDX)) && (snp_line == res_line);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_v    <= 1'b0;
         res_line <= '0;
      end else if (ll_set) begin
         res_v    <= 1'b1;
         res_line <= ll_line;
      end else if (own_sc || hit_win || hit_snp) begin
         res_v    <= 1'b0;
      end
   end

   AST_LL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      ll_set |=> (res_v && res_line == $past(ll_line)));                 // R2
   AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ll_set && hit_snp) |=> !res_v);                                  // R4
   AST_SC_CLEARS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!ll_set && own_sc) |=> !res_v);                                   // R9
   AST_WIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ll_set && hit_win) |=> !res_v);                                  // R6

endmodule

// File: rtl/llsc_pick.sv
// Fixed-priority one-hot pick; direction chosen by parameter.
module llsc_pick
   import llsc_pkg::*;
#(
   parameter int    N     = 4,
   parameter int    PW    = 2,
   parameter prio_e ORDER = PRIO_LOW_FIRST
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic          any,
   output logic [PW-1:0] idx
);

   generate
      if (ORDER == PRIO_LOW_FIRST) begin : g_low
         always_comb begin
            gnt = '0;
            idx = '0;
            any = 1'b0;
            for (int i = 0; i < N; i++) begin
               if (req[i] && !any) begin
                  gnt[i] = 1'b1;
                  idx    = PW'(i);
                  any    = 1'b1;
               end
            end
         end
      end else begin : g_high
         always_comb begin
            gnt = '0;
            idx = '0;
            any = 1'b0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i] && !any) begin
                  gnt[i] = 1'b1;
                  idx    = PW'(i);
                  any    = 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
   import llsc_pkg::*;
#(
   parameter int    N_PORTS  = 4,
   parameter int    ADDR_W   = 32,
   parameter int    DATA_W   = 32,
   parameter int    LINE_OFF = 6,
   parameter prio_e PRIO     = PRIO_LOW_FIRST,
   localparam int   LW       = ADDR_W - LINE_OFF,
   localparam int   PW       = $clog2(N_PORTS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_PORTS-1:0]          ll_valid,
   input  logic [N_PORTS*LW-1:0]       ll_line,
   input  logic [N_PORTS-1:0]          sc_valid,
   input  logic [N_PORTS*ADDR_W-1:0]   sc_addr,
   input  logic [N_PORTS*DATA_W-1:0]   sc_data,
   input  logic                        snoop_valid,
   input  logic [LW-1:0]               snoop_line,
   input  logic [PW-1:0]               snoop_src,
   output logic [N_PORTS-1:0]          sc_done,
   output logic [N_PORTS-1:0]          sc_pass,
   output logic                        st_valid,
   output logic [ADDR_W-1:0]           st_addr,
   output logic [DATA_W-1:0]           st_data,
   output logic [PW-1:0]               st_src
);

   initial begin
      assert (N_PORTS >= 2 && N_PORTS <= 64)
         else $error("llsc_monitor: N_PORTS out of range");
      assert (LINE_OFF >= 0 && LINE_OFF < ADDR_W)
         else $error("llsc_monitor: LINE_OFF must be below ADDR_W");
      assert (DATA_W >= 1)
         else $error("llsc_monitor: DATA_W must be positive");
   end

   logic [ADDR_W-1:0] sc_a  [N_PORTS];
   logic [DATA_W-1:0] sc_d  [N_PORTS];
   logic [LW-1:0]     sc_l  [N_PORTS];
   logic [LW-1:0]     ll_l  [N_PORTS];
   logic [LW-1:0]     res_l [N_PORTS];
   logic [N_PORTS-1:0] res_v;
   logic [N_PORTS-1:0] snp_hit;
   logic [N_PORTS-1:0] eligible;
   logic [N_PORTS-1:0] gnt;
   logic               gnt_any;
   logic [PW-1:0]      gnt_idx;
   logic [LW-1:0]      win_line;

   genvar g;
   generate
      for (g = 0; g < N_PORTS; g++) begin : g_port
         assign sc_a[g] = sc_addr[g*ADDR_W +: ADDR_W];
         assign sc_d[g] = sc_data[g*DATA_W +: DATA_W];
         assign sc_l[g] = sc_a[g][ADDR_W-1:LINE_OFF];
         assign ll_l[g] = ll_line[g*LW +: LW];

         // A foreign write to this SC's line in the same cycle is ordered first.
         assign snp_hit[g]  = snoop_valid && (snoop_src != PW'(g)) &&
                              (snoop_line == sc_l[g]);
         assign eligible[g] = sc_valid[g] && res_v[g] &&
                              (res_l[g] == sc_l[g]) && !snp_hit[g];

         llsc_resv_slot #(
            .LW  (LW),
            .PW  (PW),
            .IDX (g)
         ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .ll_set   (ll_valid[g]),
            .ll_line  (ll_l[g]),
            .own_sc   (sc_valid[g]),
            .win_v    (gnt_any),
            .win_line (win_line),
            .snp_v    (snoop_valid),
            .snp_line (snoop_line),
            .snp_src  (snoop_src),
            .res_v    (res_v[g]),
            .res_line (res_l[g])
         );

         AST_EMPTY_SLOT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
            (sc_valid[g] && !res_v[g]) |=> !sc_pass[g]);                  // R7
         AST_SNOOP_BEATS_SC: assert property (@(posedge clk) disable iff (!rst_n)
            (sc_valid[g] && snp_hit[g]) |=> !sc_pass[g]);                 // R10
         AST_OTHER_LINE_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
            (sc_valid[g] && res_l[g] != sc_l[g]) |=> !sc_pass[g]);        // R5
      end
   endgenerate

   llsc_pick #(
      .N     (N_PORTS),
      .PW    (PW),
      .ORDER (PRIO)
   ) u_pick (
      .req (eligible),
      .gnt (gnt),
      .any (gnt_any),
      .idx (gnt_idx)
   );

   assign win_line = sc_l[gnt_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sc_done  <= '0;
         sc_pass  <= '0;
         st_valid <= 1'b0;
         st_addr  <= '0;
         st_data  <= '0;
         st_src   <= '0;
      end else begin
         sc_done  <= sc_valid;
         sc_pass  <= gnt;
         st_valid <= gnt_any;
         if (gnt_any) begin
            st_addr <= sc_a[gnt_idx];
            st_data <= sc_d[gnt_idx];
            st_src  <= gnt_idx;
         end
      end
   end

   AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sc_pass));                                                 // R8
   AST_FAIL_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_pass == '0) |-> !st_valid);                                     // R3
   AST_PASS_HAS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_pass & ~sc_done) == '0);                                        // R11
   AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_valid != '0) |=> (sc_done == $past(sc_valid)));                 // R11

endmodule

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;
   import llsc_pkg::*;

   localparam int N   = 4;
   localparam int AW  = 16;
   localparam int DW  = 16;
   localparam int OFF = 4;
   localparam int LW  = AW - OFF;
   localparam int PW  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic           llv [N];
   logic [AW-1:0]  lla [N];
   logic           scv [N];
   logic [AW-1:0]  sca [N];
   logic [DW-1:0]  scd [N];
   logic           snv;
   logic [AW-1:0]  sna;
   logic [PW-1:0]  sns;

   logic [N-1:0]    ll_valid, sc_valid;
   logic [N*LW-1:0] ll_line;
   logic [N*AW-1:0] sc_addr;
   logic [N*DW-1:0] sc_data;
   logic [N-1:0]    sc_done, sc_pass;
   logic            st_valid;
   logic [AW-1:0]   st_addr;
   logic [DW-1:0]   st_data;
   logic [PW-1:0]   st_src;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         ll_valid[i]            = llv[i];
         ll_line[i*LW +: LW]    = lla[i][AW-1:OFF];
         sc_valid[i]            = scv[i];
         sc_addr[i*AW +: AW]    = sca[i];
         sc_data[i*DW +: DW]    = scd[i];
      end
   end

   llsc_monitor #(
      .N_PORTS (N), .ADDR_W (AW), .DATA_W (DW), .LINE_OFF (OFF),
      .PRIO (PRIO_LOW_FIRST)
   ) uut (
      .clk (clk), .rst_n (rst_n),
      .ll_valid (ll_valid), .ll_line (ll_line),
      .sc_valid (sc_valid), .sc_addr (sc_addr), .sc_data (sc_data),
      .snoop_valid (snv), .snoop_line (sna[AW-1:OFF]), .snoop_src (sns),
      .sc_done (sc_done), .sc_pass (sc_pass),
      .st_valid (st_valid), .st_addr (st_addr), .st_data (st_data),
      .st_src (st_src)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // Reference model state
   logic          mv [N];
   logic [LW-1:0] ml [N];

   function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
      return a[AW-1:OFF];
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      for (int i = 0; i < N; i++) begin
         llv[i] = 0; lla[i] = '0; scv[i] = 0; sca[i] = '0; scd[i] = '0;
      end
      snv = 0; sna = '0; sns = '0;
   endtask

   // Compute expected results from model and current inputs, advance one clock,
   // then compare at the following falling edge.
   task automatic step(input string tag);
      logic [N-1:0] e_pass, e_done;
      int w;
      logic [LW-1:0] wl;
      w = -1;
      for (int i = 0; i < N; i++) begin
         bit foreign;
         foreign = snv && (int'(sns) != i) && (line_of(sna) == line_of(sca[i]));
         e_done[i] = scv[i];
         e_pass[i] = 1'b0;
         if (w < 0 && scv[i] && mv[i] && ml[i] == line_of(sca[i]) && !foreign)
            w = i;
      end
      if (w >= 0) e_pass[w] = 1'b1;
      wl = (w >= 0) ? line_of(sca[w]) : '0;
      for (int i = 0; i < N; i++) begin
         if (llv[i]) begin
            mv[i] = 1; ml[i] = line_of(lla[i]);
         end else if (scv[i] || (w >= 0 && ml[i] == wl) ||
                      (snv && int'(sns) != i && line_of(sna) == ml[i])) begin
            mv[i] = 0;
         end
      end
      @(posedge clk);
      @(negedge clk);
      chk(sc_done == e_done, tag, "sc_done", 64'(sc_done), 64'(e_done));
      chk(sc_pass == e_pass, tag, "sc_pass", 64'(sc_pass), 64'(e_pass));
      chk(st_valid == (w >= 0), tag, "st_valid", 64'(st_valid), 64'(w >= 0));
      if (w >= 0 && st_valid) begin
         chk(st_addr == sca[w] && st_data == scd[w] && int'(st_src) == w, tag,
             "store addr/data/src", {16'h0, st_addr, st_data, 14'h0, st_src},
             {16'h0, sca[w], scd[w], 14'h0, 2'(w)});
      end
   endtask

   task automatic do_ll(input int p, input logic [AW-1:0] a, input string tag);
      idle_inputs(); llv[p] = 1; lla[p] = a; step(tag);
   endtask

   task automatic do_sc(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input string tag);
      idle_inputs(); scv[p] = 1; sca[p] = a; scd[p] = d; step(tag);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd1357);
      idle_inputs();
      for (int i = 0; i < N; i++) begin mv[i] = 0; ml[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: reset state
      chk(sc_done == 0 && sc_pass == 0 && st_valid == 0, "R1", "outputs after reset",
          {sc_done, sc_pass, 7'h0, st_valid}, 64'h0);
      do_sc(0, 16'h0010, 16'h1111, "R1/R7 empty slot after reset");

      // R2 and R11: basic pass with store, and no early response
      do_ll(1, 16'h0120, "R2 arm");
      idle_inputs(); scv[1] = 1; sca[1] = 16'h0124; scd[1] = 16'hBEEF;
      #1 chk(sc_done == 0, "R11", "sc_done before edge", 64'(sc_done), 64'h0);
      step("R2/R11 pass and store");

      // R5: line granularity
      do_ll(2, 16'h0340, "R5 arm");
      do_sc(2, 16'h034C, 16'h2222, "R5 other word same line passes");
      do_ll(2, 16'h0340, "R5 rearm");
      do_sc(2, 16'h0350, 16'h2223, "R5 different line fails");

      // R4: foreign snoop clears, own snoop does not
      do_ll(0, 16'h0500, "R4 arm");
      idle_inputs(); snv = 1; sna = 16'h0508; sns = 3; step("R4 foreign snoop");
      do_sc(0, 16'h0500, 16'h3333, "R4 fails after foreign write");
      do_ll(0, 16'h0500, "R4 rearm");
      idle_inputs(); snv = 1; sna = 16'h0500; sns = 0; step("R4 own snoop");
      do_sc(0, 16'h0500, 16'h3334, "R4 passes after own write");

      // R10: same-cycle foreign snoop beats SC
      do_ll(1, 16'h0600, "R10 arm");
      idle_inputs(); scv[1] = 1; sca[1] = 16'h0600; scd[1] = 16'h4444;
      snv = 1; sna = 16'h0604; sns = 2; step("R10 same-cycle snoop");

      // R6: winner clears other holders
      do_ll(0, 16'h0700, "R6 arm p0");
      do_ll(1, 16'h0700, "R6 arm p1");
      do_ll(2, 16'h0708, "R6 arm p2");
      do_sc(2, 16'h0700, 16'h5555, "R6 first SC passes");
      do_sc(0, 16'h0700, 16'h5556, "R6 later SC p0 fails");
      do_sc(1, 16'h0700, 16'h5557, "R6 later SC p1 fails");

      // R8: simultaneous eligible SCs
      idle_inputs();
      for (int i = 0; i < N; i++) begin llv[i] = 1; lla[i] = 16'h0800; end
      step("R8 arm all");
      idle_inputs();
      for (int i = 0; i < N; i++) begin scv[i] = 1; sca[i] = 16'h0800; scd[i] = 16'(i); end
      step("R8 same-line race, port 0 wins");
      do_ll(1, 16'h0900, "R8 arm p1");
      do_ll(3, 16'h0A00, "R8 arm p3");
      idle_inputs();
      scv[1] = 1; sca[1] = 16'h0900; scd[1] = 16'h0091;
      scv[3] = 1; sca[3] = 16'h0A00; scd[3] = 16'h00A3;
      step("R8 one store per cycle");

      // R9: own SC and new LL replace
      do_ll(3, 16'h0B00, "R9 arm");
      do_ll(3, 16'h0C00, "R9 replace");
      do_sc(3, 16'h0B00, 16'h6666, "R9 old line fails");
      do_ll(3, 16'h0C00, "R9 rearm");
      do_sc(3, 16'h0D00, 16'h6667, "R9 mismatched SC");
      do_sc(3, 16'h0C00, 16'h6668, "R9 cleared by own SC");

      // R11: LL arms even when a winner on that line passes the same cycle
      do_ll(0, 16'h0E00, "R11 arm p0");
      idle_inputs(); scv[0] = 1; sca[0] = 16'h0E00; scd[0] = 16'h7777;
      llv[2] = 1; lla[2] = 16'h0E00; step("R11 LL beside winner");
      do_sc(2, 16'h0E00, 16'h7778, "R11 new LL survives");

      // R6: spin-lock acquire, one owner per release
      for (int round = 0; round < 20; round++) begin
         logic [N-1:0] pending;
         int passes;
         int owner;
         idle_inputs();
         for (int i = 0; i < N; i++) begin llv[i] = 1; lla[i] = 16'h0F00; end
         step("R6 lock LL");
         pending = '1; passes = 0; owner = 0;
         for (int t = 0; t < 12 && pending != 0; t++) begin
            logic [N-1:0] m;
            m = (t == 11) ? pending : (N'($urandom) & pending);
            idle_inputs();
            for (int i = 0; i < N; i++) if (m[i]) begin
               scv[i] = 1; sca[i] = 16'h0F00; scd[i] = 16'(i + 1);
            end
            step("R6 lock SC");
            for (int i = 0; i < N; i++) if (sc_pass[i]) begin passes++; owner = i; end
            pending &= ~m;
         end
         chk(passes == 1, "R6", "lock acquisitions per release", 64'(passes), 64'd1);
         idle_inputs(); snv = 1; sna = 16'h0F00; sns = PW'(owner);
         step("R6 lock release");
      end

      // Constrained random traffic on a few hot lines
      for (int c = 0; c < 3000; c++) begin
         idle_inputs();
         for (int i = 0; i < N; i++) begin
            int r;
            logic [AW-1:0] a;
            r = int'($urandom % 10);
            a = {8'h01, 4'($urandom % 4), 4'($urandom)};
            if (r < 3) begin llv[i] = 1; lla[i] = a; end
            else if (r < 6) begin scv[i] = 1; sca[i] = a; scd[i] = 16'($urandom); end
         end
         if ($urandom % 4 == 0) begin
            snv = 1; sna = {8'h01, 4'($urandom % 4), 4'h0}; sns = PW'($urandom);
         end
         step("R2-mix random");
      end

      idle_inputs();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule